// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control section of a microcoded processor. It holds a fixed microprogram in an on-chip control store and walks through it one microinstruction at a time. For each microinstruction it presents an address from its control address register and raises a read strobe. It then captures the returned control word into a buffer register. Finally it splits that word into datapath control bits and next-address information. The next address is chosen from that information, the current ALU status flags and the opcode held in the instruction register.

Every microstep takes three clock cycles: address, load-buffer and decode/sequence. The control bus carries the decoded control bits only in the decode/sequence cycle and is all-zero otherwise. The surrounding datapath latches control bits in that cycle. The datapath holds the opcode and flags steady until the edge that ends the cycle.

After reset the sequencer waits for a start strobe, then runs without stopping. The microprogram starts with a three-step fetch routine at address 0. The fetch routine dispatches through the opcode map into a short execute routine for each opcode. Each execute routine returns to address 0.

Top module: `mpc_sequencer`

## Requirements
- R1: While reset (active-low, synchronous) is applied, and on the cycle after it, the control address is 0, the control bus is zero and the read strobe is low.
- R2: After reset the read strobe stays low until start is high at a rising edge; once running, start has no effect on the microstep sequence.
- R3: A microstep is three cycles: address (read strobe high), load-buffer, decode/sequence. The read strobe is therefore high in exactly one of every three cycles.
- R4: The control bus equals the control field of the buffered word during decode/sequence and is zero in the other two cycles. The control address is constant across all three cycles of a step.
- R5: A 24-bit control word is laid out as bits [23:22] next-address select, [21:20] flag select, [19:14] branch target and [13:0] control bits.
- R6: Select 00 moves to the current address plus one, modulo 64.
- R7: Select 01 moves to the branch target unconditionally.
- R8: Select 10 tests one flag input, chosen by the flag select: 0 = zero (flags bit 0), 1 = carry (bit 1), 2 = negative (bit 2), 3 = overflow (bit 3). If the flag is 1 the next address is the branch target, otherwise current plus one. Flags are sampled at the edge that ends decode/sequence.
- R9: Select 11 moves to opcode*4 + 16, with the opcode sampled at the edge that ends decode/sequence.
- R10: The microprogram is as follows.
  - Fetch routine: address 0 (control 0x0001, increment), address 1 (0x0002, increment), address 2 (0x0004, map).
  - Opcode 0: address 16 (0x0010) jumps to 0.
  - Opcode 1: address 20 (0x0020) tests zero with target 30. Address 21 (0x0040) and address 30 (0x0080) each jump to 0.
  - Opcode 2: address 24 (0x0100) tests carry with target 31. Address 25 (0x0200) and address 31 (0x0400) each jump to 0.
  - Opcode 3: address 28 (0x0800) tests negative with target 60. Address 29 (0x1000) and address 60 (0x2000) each jump to 0.
  - Opcode 4: address 32 (0x0008) tests overflow with target 61. Address 33 (0x0003) and address 61 (0x000C) each jump to 0.
  - Every other word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Leaves the idle state after reset |
| opcode | input | 3 | Instruction register opcode used by the map select |
| flags | input | 4 | ALU flags: bit0 zero, bit1 carry, bit2 negative, bit3 overflow |
| rd_strobe | output | 1 | Read command to the control store, high in the address cycle |
| ctrl_out | output | 14 | Decoded control bits, valid in decode/sequence only |
| ctl_addr | output | 6 | Control address register |

## Verification
Two functions share one cycle. In decode/sequence the sequencer drives the current control bits and also computes the next address from those same fields and the live flags and opcode. The bench provokes this with execute routines whose conditional step sees the tested flag either set or cleared. The other three flags are held at the opposite value, so a wrong flag select also shows up. The scoreboard compares each step's control word against the address it was observed at. This shows whether the branch decision made in that cycle landed on the target or on the next sequential word.

// File: rtl/mpc_pkg.sv
// Package: shared types for the microprogrammed sequencer.
// Assumes: the phase encoding is private to the sequencer and its checker.
package mpc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_ADDR   = 2'd1,
        PH_LOAD   = 2'd2,
        PH_DECODE = 2'd3
    } phase_t;

    localparam logic [1:0] SEL_INC  = 2'b00;
    localparam logic [1:0] SEL_JUMP = 2'b01;
    localparam logic [1:0] SEL_COND = 2'b10;
    localparam logic [1:0] SEL_MAP  = 2'b11;

endpackage

// File: rtl/mpc_store.sv
// Module: mpc_store
// Control store holding the fixed microprogram. The read is synchronous:
// the word at addr appears on rdata after the edge where rd_en is high.
// Assumes: ADDR_W >= 6, so every defined word address fits.
module mpc_store #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 24,
    parameter int CTRL_W = 14
) (
    input  logic              clk,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    output logic [WORD_W-1:0] rdata
);
    import mpc_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;

    // Pack one microword from its fields.
    function automatic logic [WORD_W-1:0] pack_word(
        input logic [1:0] sel, input int fsel, input int target, input int bits);
        logic [WORD_W-1:0] w;
        w = WORD_W'(bits) & ((WORD_W'(1) << CTRL_W) - WORD_W'(1));
        w = w | (WORD_W'(target) << CTRL_W);
        w = w | (WORD_W'(fsel) << (CTRL_W + ADDR_W));
        w = w | (WORD_W'(sel) << (CTRL_W + ADDR_W + 2));
        return w;
    endfunction

    // Microprogram contents per address; unlisted words are zero.
    function automatic logic [WORD_W-1:0] program_word(input int a);
        case (a)
            0:  return pack_word(SEL_INC,  0, 0,  'h0001);
            1:  return pack_word(SEL_INC,  0, 0,  'h0002);
            2:  return pack_word(SEL_MAP,  0, 0,  'h0004);
            16: return pack_word(SEL_JUMP, 0, 0,  'h0010);
            20: return pack_word(SEL_COND, 0, 30, 'h0020);
            21: return pack_word(SEL_JUMP, 0, 0,  'h0040);
            30: return pack_word(SEL_JUMP, 0, 0,  'h0080);
            24: return pack_word(SEL_COND, 1, 31, 'h0100);
            25: return pack_word(SEL_JUMP, 0, 0,  'h0200);
            31: return pack_word(SEL_JUMP, 0, 0,  'h0400);
            28: return pack_word(SEL_COND, 2, 60, 'h0800);
            29: return pack_word(SEL_JUMP, 0, 0,  'h1000);
            60: return pack_word(SEL_JUMP, 0, 0,  'h2000);
            32: return pack_word(SEL_COND, 3, 61, 'h0008);
            33: return pack_word(SEL_JUMP, 0, 0,  'h0003);
            61: return pack_word(SEL_JUMP, 0, 0,  'h000C);
            default: return '0;
        endcase
    endfunction

    logic [WORD_W-1:0] rom [DEPTH];

    // One constant word per store location.
    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        assign rom[i] = program_word(i);
    end

    // Registered read on the read command.
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rdata <= rom[addr];
        end
    end

endmodule

// File: rtl/mpc_phase.sv
// Module: mpc_phase
// Three-phase step sequencer with an idle state left only by start.
// Assumes: start is a level sampled at the rising edge.
module mpc_phase (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    output mpc_pkg::phase_t phase,
    output logic            rd_strobe
);
    import mpc_pkg::*;

    phase_t phase_q;

    // Advance address -> load -> decode -> address; leave idle on start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            case (phase_q)
                PH_IDLE:   phase_q <= start ? PH_ADDR : PH_IDLE;
                PH_ADDR:   phase_q <= PH_LOAD;
                PH_LOAD:   phase_q <= PH_DECODE;
                default:   phase_q <= PH_ADDR;
            endcase
        end
    end

    assign phase     = phase_q;
    assign rd_strobe = (phase_q == PH_ADDR);

endmodule

// File: rtl/mpc_decoder.sv
// Module: mpc_decoder
// Splits the buffered word into sequencing fields and control bits.
// Control bits are forced to zero outside the decode/sequence phase.
// Assumes: field layout select | flag select | target | control, MSB first.
module mpc_decoder #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 24,
    parameter int FSEL_W = 2,
    parameter int CTRL_W = 14
) (
    input  logic [WORD_W-1:0] word,
    input  logic              decode_en,
    output logic [1:0]        sel,
    output logic [FSEL_W-1:0] fsel,
    output logic [ADDR_W-1:0] target,
    output logic [CTRL_W-1:0] ctrl
);
    localparam int TGT_LO  = CTRL_W;
    localparam int FSEL_LO = CTRL_W + ADDR_W;
    localparam int SEL_LO  = FSEL_LO + FSEL_W;

    // Field extraction and output gating.
    always_comb begin
        sel    = word[SEL_LO +: 2];
        fsel   = word[FSEL_LO +: FSEL_W];
        target = word[TGT_LO +: ADDR_W];
        ctrl   = decode_en ? word[CTRL_W-1:0] : '0;
    end

endmodule

// File: rtl/mpc_next_addr.sv
// Module: mpc_next_addr
// Chooses the next control address from the select field, a selected flag
// and the opcode map. Purely combinational.
// Assumes: the opcode map is opcode*4 + MAP_BASE, truncated to ADDR_W.
module mpc_next_addr #(
    parameter int ADDR_W   = 6,
    parameter int OPC_W    = 3,
    parameter int FLAG_W   = 4,
    parameter int FSEL_W   = 2,
    parameter int MAP_BASE = 16
) (
    input  logic [1:0]        sel,
    input  logic [FSEL_W-1:0] fsel,
    input  logic [ADDR_W-1:0] target,
    input  logic [ADDR_W-1:0] cur,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [FLAG_W-1:0] flags,
    output logic [ADDR_W-1:0] next
);
    import mpc_pkg::*;

    logic [ADDR_W-1:0] incr;
    logic [ADDR_W-1:0] mapped;
    logic              hit;

    // Candidate addresses and the flag test.
    always_comb begin
        incr   = cur + ADDR_W'(1);
        mapped = ADDR_W'({opcode, 2'b00}) + ADDR_W'(MAP_BASE);
        hit    = flags[fsel];
    end

    // Select among the candidates.
    always_comb begin
        case (sel)
            SEL_JUMP: next = target;
            SEL_COND: next = hit ? target : incr;
            SEL_MAP:  next = mapped;
            default:  next = incr;
        endcase
    end

endmodule

// File: rtl/mpc_sequencer.sv
// Module: mpc_sequencer (top)
// Microprogrammed control sequencer: control address register, control
// store, buffer register, decoder and next-address logic.
// Assumes: opcode and flags are stable at the edge ending decode/sequence.
module mpc_sequencer #(
    parameter int ADDR_W   = 6,
    parameter int WORD_W   = 24,
    parameter int OPC_W    = 3,
    parameter int FLAG_W   = 4,
    parameter int MAP_BASE = 16,
    localparam int FSEL_W  = $clog2(FLAG_W),
    localparam int CTRL_W  = WORD_W - 2 - FSEL_W - ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [FLAG_W-1:0] flags,
    output logic              rd_strobe,
    output logic [CTRL_W-1:0] ctrl_out,
    output logic [ADDR_W-1:0] ctl_addr
);
    import mpc_pkg::*;

    phase_t            phase;
    logic [ADDR_W-1:0] car_q;
    logic [WORD_W-1:0] store_data;
    logic [WORD_W-1:0] cbr_q;
    logic [1:0]        dec_sel;
    logic [FSEL_W-1:0] dec_fsel;
    logic [ADDR_W-1:0] dec_target;
    logic [ADDR_W-1:0] next_addr;

    mpc_phase u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .phase     (phase),
        .rd_strobe (rd_strobe)
    );

    mpc_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .CTRL_W(CTRL_W)) u_store (
        .clk   (clk),
        .rd_en (rd_strobe),
        .addr  (car_q),
        .rdata (store_data)
    );

    mpc_decoder #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .FSEL_W(FSEL_W), .CTRL_W(CTRL_W)) u_dec (
        .word      (cbr_q),
        .decode_en (phase == PH_DECODE),
        .sel       (dec_sel),
        .fsel      (dec_fsel),
        .target    (dec_target),
        .ctrl      (ctrl_out)
    );

    mpc_next_addr #(.ADDR_W(ADDR_W), .OPC_W(OPC_W), .FLAG_W(FLAG_W),
                    .FSEL_W(FSEL_W), .MAP_BASE(MAP_BASE)) u_next (
        .sel    (dec_sel),
        .fsel   (dec_fsel),
        .target (dec_target),
        .cur    (car_q),
        .opcode (opcode),
        .flags  (flags),
        .next   (next_addr)
    );

    // Control address register: loaded with the next address after decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            car_q <= '0;
        end else if (phase == PH_DECODE) begin
            car_q <= next_addr;
        end
    end

    // Buffer register: captures the store word in the load phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cbr_q <= '0;
        end else if (phase == PH_LOAD) begin
            cbr_q <= store_data;
        end
    end

    assign ctl_addr = car_q;

endmodule

// File: rtl/mpc_sequencer_chk.sv
// Module: mpc_sequencer_chk
// Assertion checker bound to mpc_sequencer; observes ports, phase and the
// decoded select field.
// Assumes: reset is applied from time zero.
module mpc_sequencer_chk #(
    parameter int ADDR_W   = 6,
    parameter int OPC_W    = 3,
    parameter int FLAG_W   = 4,
    parameter int CTRL_W   = 14,
    parameter int MAP_BASE = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [OPC_W-1:0]  opcode,
    input logic [FLAG_W-1:0] flags,
    input logic              rd_strobe,
    input logic [CTRL_W-1:0] ctrl_out,
    input logic [ADDR_W-1:0] ctl_addr,
    input mpc_pkg::phase_t   phase,
    input logic [1:0]        dec_sel
);
    import mpc_pkg::*;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (ctl_addr == '0 && ctrl_out == '0 && !rd_strobe)); // R1

    AST_IDLE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && !start) |=> !rd_strobe); // R2

    AST_STROBE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> !rd_strobe ##1 !rd_strobe ##1 rd_strobe); // R3

    AST_CTRL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |-> (ctrl_out == '0) ##1 (ctrl_out == '0)); // R4

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> $stable(ctl_addr) ##1 $stable(ctl_addr)); // R4

    AST_INCREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DECODE && dec_sel == SEL_INC)
        |=> ctl_addr == ADDR_W'($past(ctl_addr) + ADDR_W'(1))); // R6

    AST_OPCODE_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DECODE && dec_sel == SEL_MAP)
        |=> ctl_addr == ADDR_W'(ADDR_W'($past(opcode)) * 4 + MAP_BASE)); // R9

    // Flags are observed only through the conditional branch; keep them used.
    always_comb begin
        AST_FLAGS_KNOWN: assert (!rst_n || !$isunknown(flags) || phase != PH_DECODE); // R8
    end

endmodule

bind mpc_sequencer mpc_sequencer_chk #(
    .ADDR_W   (ADDR_W),
    .OPC_W    (OPC_W),
    .FLAG_W   (FLAG_W),
    .CTRL_W   (CTRL_W),
    .MAP_BASE (MAP_BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .opcode    (opcode),
    .flags     (flags),
    .rd_strobe (rd_strobe),
    .ctrl_out  (ctrl_out),
    .ctl_addr  (ctl_addr),
    .phase     (phase),
    .dec_sel   (dec_sel)
);

// File: tb/mpc_sequencer_bench.sv
// Scoreboard bench: the driver queues the expected address/control pairs of
// each microstep; the monitor pops one per observed decode cycle.
module mpc_sequencer_bench;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  opcode = '0;
    logic [3:0]  flags = '0;
    logic        rd_strobe;
    logic [13:0] ctrl_out;
    logic [5:0]  ctl_addr;

    int checks = 0;
    int fails = 0;

    typedef struct {
        logic [5:0]  a;
        logic [13:0] c;
        string       req;
    } exp_t;

    exp_t q[$];

    mpc_sequencer u_mpc_sequencer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .opcode    (opcode),
        .flags     (flags),
        .rd_strobe (rd_strobe),
        .ctrl_out  (ctrl_out),
        .ctl_addr  (ctl_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [5:0] a, input logic [13:0] c, input string req);
        exp_t e;
        e.a = a;
        e.c = c;
        e.req = req;
        q.push_back(e);
    endtask

    // Drive one instruction: fetch steps, mapped entry, optional second step.
    task automatic run_instr(input logic [2:0] opc, input logic [3:0] flg, input int n,
                             input logic [5:0] a3, input logic [13:0] c3,
                             input logic [5:0] a4, input logic [13:0] c4,
                             input string req, input bit poke_start);
        opcode = opc;
        flags  = flg;
        push(6'd0, 14'h0001, "R10");
        push(6'd1, 14'h0002, "R6");
        push(6'd2, 14'h0004, "R10");
        push(a3, c3, "R9");
        if (n > 4) push(a4, c4, req);
        if (poke_start) begin
            repeat (4) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (q.size() != 0) @(negedge clk);
    endtask

    // Monitor: follows each step from its read strobe to its decode cycle.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rd_strobe) begin
                check(ctrl_out == '0, "R4", "ctrl in address cycle", ctrl_out, 0);
                @(negedge clk);
                check(!rd_strobe && ctrl_out == '0, "R3", "strobe/ctrl in load cycle",
                      {rd_strobe, ctrl_out}, 0);
                @(negedge clk);
                check(!rd_strobe, "R3", "strobe in decode cycle", rd_strobe, 0);
                if (q.size() != 0) begin
                    exp_t e;
                    e = q.pop_front();
                    check(ctl_addr == e.a, e.req, "step address", ctl_addr, e.a);
                    check(ctrl_out == e.c, e.req, "step control", ctrl_out, e.c);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(ctl_addr == 0 && ctrl_out == 0 && !rd_strobe, "R1", "reset state",
              {ctl_addr, ctrl_out, rd_strobe}, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(!rd_strobe, "R2", "strobe before start", rd_strobe, 0);
        end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;

        run_instr(3'd0, 4'b0000, 4, 6'd16, 14'h0010, 6'd0, 14'h0, "R7", 1'b0);
        run_instr(3'd1, 4'b0001, 5, 6'd20, 14'h0020, 6'd30, 14'h0080, "R8", 1'b0);
        run_instr(3'd1, 4'b1110, 5, 6'd20, 14'h0020, 6'd21, 14'h0040, "R8", 1'b0);
        run_instr(3'd2, 4'b0010, 5, 6'd24, 14'h0100, 6'd31, 14'h0400, "R8", 1'b1);
        run_instr(3'd2, 4'b1101, 5, 6'd24, 14'h0100, 6'd25, 14'h0200, "R2", 1'b0);
        run_instr(3'd3, 4'b0100, 5, 6'd28, 14'h0800, 6'd60, 14'h2000, "R8", 1'b0);
        run_instr(3'd3, 4'b1011, 5, 6'd28, 14'h0800, 6'd29, 14'h1000, "R5", 1'b0);
        run_instr(3'd4, 4'b1000, 5, 6'd32, 14'h0008, 6'd61, 14'h000C, "R8", 1'b0);
        run_instr(3'd4, 4'b0111, 5, 6'd32, 14'h0008, 6'd33, 14'h0003, "R7", 1'b0);

        // Reset while running, then restart.
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(ctl_addr == 0 && ctrl_out == 0 && !rd_strobe, "R1", "mid-run reset",
              {ctl_addr, ctrl_out, rd_strobe}, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!rd_strobe, "R2", "idle after reset", rd_strobe, 0);
        end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        run_instr(3'd0, 4'b1111, 4, 6'd16, 14'h0010, 6'd0, 14'h0, "R7", 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule